// File: doc/BRIEF.md
# Peripheral Clock Gate Sequencer

This block powers one peripheral's clock domain up and down through four control bits: a reset release, a bus clock gate, a module clock gate and a memory-bus clock gate. Each bit is chosen at build time to be present or absent. Each present bit is either private to this peripheral or shared with a group of sibling peripherals. A shared bit is driven only when the whole group's user mask moves between empty and non-empty.

A request names the mask slot it accounts against. On an enable, the sequencer first walks the shared bits and then the private bits, releasing reset before opening the bus, module and memory-bus gates. On a disable, it walks the private bits first and then the shared bits, in the opposite gate order. Each step occupies one clock. Build options make the module gate active-low, keep the reset bit untouched, or lock the block against all requests. A combined status output tells whether every present bit is in its open state.

Top module: `periph_gate_seq`

## Requirements
- R1: After a synchronous reset, every gate is closed, reset is asserted (`rst_release`=0), `user_mask` is zero, `busy` is 0 and `enabled` is 0.
- R2: An accepted enable runs eight steps, one per clock. The first four steps apply to shared bits and the last four to private bits. Within each group the order is reset release, bus, module, memory-bus. Step k takes effect on the (k+1)th rising edge after the accepting edge.
- R3: An accepted disable runs eight steps, one per clock. The first four steps apply to private bits and the last four to shared bits. Within each group the order is memory-bus, module, bus, reset assert.
- R4: On an enable, the shared bits are switched on only if `user_mask` was all zero before the request. Bit `req_slot` of `user_mask` is set on the accepting edge.
- R5: On a disable, bit `req_slot` of `user_mask` is cleared. Shared bits are switched off only when the mask becomes zero. A disable that finds the mask already zero changes neither the mask nor any shared bit.
- R6: `busy` is high for exactly eight cycles after acceptance. Requests that arrive while `busy` is high are ignored. At most one gate output changes per cycle, and none changes while idle. If enable and disable arrive together, the enable is taken.
- R7: With the active-low option, the `mod_gate` output is 0 when the module gate is open and 1 when it is closed, including after reset.
- R8: With the keep-reset option, `rst_release` stays 0 through enables and disables.
- R9: With the read-only option, requests never start a sequence: `busy`, `user_mask` and all gate outputs keep their reset values.
- R10: `enabled` is the AND of the open state of each present bit. An absent bit counts as open, and its output stays at its closed level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_req | input | 1 | Enable request, sampled when idle |
| dis_req | input | 1 | Disable request, sampled when idle |
| req_slot | input | $clog2(NUM_USERS) | User-mask slot charged by the request |
| busy | output | 1 | A sequence is running |
| rst_release | output | 1 | 1 releases the peripheral from reset |
| bus_gate | output | 1 | Bus clock gate, 1 = open |
| mod_gate | output | 1 | Module clock gate, polarity set by MOD_ACTIVE_LOW |
| mem_gate | output | 1 | Memory-bus clock gate, 1 = open |
| enabled | output | 1 | All present bits open |
| user_mask | output | NUM_USERS | Shared-group user mask |

## Verification
Several properties are checked on every cycle. At most one gate moves per cycle and nothing moves while idle. The mask stays still during a sequence. An empty-mask disable leaves the shared bits inert. A read-only build never goes busy, and a keep-reset build never releases reset. The exact step order in each direction, the rule that shared bits move only on empty/non-empty transitions, the active-low module level and the status with absent bits are shown only by the bench's scenarios. These scenarios compare every sequence cycle by cycle against an independent model.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

    localparam int N_GATES = 4;
    localparam int N_STEPS = 2 * N_GATES;
    localparam int STEP_W  = $clog2(N_STEPS);

    // Gate index order is the power-up order
    typedef enum logic [1:0] {
        G_RST = 2'd0,
        G_BUS = 2'd1,
        G_MOD = 2'd2,
        G_MEM = 2'd3
    } gate_e;

    typedef enum logic {
        DIR_ON  = 1'b0,
        DIR_OFF = 1'b1
    } dir_e;

    typedef struct packed {
        logic  valid;
        gate_e gate;
        logic  shared_grp;
        logic  turn_on;
    } step_s;

    // Power-up: shared half first, gates ascending.
    // Power-down: private half first, gates descending.
    function automatic step_s decode_step(input dir_e d,
                                          input logic [STEP_W-1:0] s,
                                          input logic live);
        step_s r;
        r.valid      = live;
        r.turn_on    = (d == DIR_ON);
        r.shared_grp = (d == DIR_ON) ? ~s[STEP_W-1] : s[STEP_W-1];
        r.gate       = (d == DIR_ON) ? gate_e'(s[1:0]) : gate_e'(~s[1:0]);
        return r;
    endfunction

endpackage

// File: rtl/pgs_seq_ctrl.sv
module pgs_seq_ctrl
    import pgs_pkg::*;
#(
    parameter int NUM_USERS = 4,
    parameter bit READ_ONLY = 1'b0
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         en_req,
    input  logic                         dis_req,
    input  logic [$clog2(NUM_USERS)-1:0] req_slot,
    output logic                         busy,
    output step_s                        act,
    output logic                         shared_go,
    output logic [NUM_USERS-1:0]         user_mask
);

    logic                 busy_q;
    logic [STEP_W-1:0]    step_q;
    dir_e                 dir_q;
    logic                 go_q;
    logic [NUM_USERS-1:0] mask_q;
    logic [NUM_USERS-1:0] slot_bit;
    logic                 accept;

    assign slot_bit = NUM_USERS'(1) << req_slot;
    assign accept   = !busy_q && !READ_ONLY && (en_req || dis_req);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            step_q <= '0;
            dir_q  <= DIR_ON;
            go_q   <= 1'b0;
            mask_q <= '0;
        end else if (accept) begin
            busy_q <= 1'b1;
            step_q <= '0;
            if (en_req) begin
                dir_q  <= DIR_ON;
                go_q   <= (mask_q == '0);
                mask_q <= mask_q | slot_bit;
            end else begin
                dir_q  <= DIR_OFF;
                go_q   <= (mask_q != '0) && ((mask_q & ~slot_bit) == '0);
                mask_q <= mask_q & ~slot_bit;
            end
        end else if (busy_q) begin
            step_q <= step_q + 1'b1;
            if (step_q == STEP_W'(N_STEPS - 1))
                busy_q <= 1'b0;
        end
    end

    assign busy      = busy_q;
    assign act       = decode_step(dir_q, step_q, busy_q);
    assign shared_go = go_q;
    assign user_mask = mask_q;

    // R6
    mask_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && $past(busy_q)) |-> $stable(mask_q));

    // R5
    empty_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_q && !en_req && dis_req && mask_q == '0) |=> (!go_q && mask_q == '0));

    generate
        if (READ_ONLY) begin : g_ro_chk
            // R9
            ro_idle_chk: assert property (@(posedge clk) disable iff (rst)
                !busy_q && mask_q == '0);
        end
    endgenerate

endmodule

// File: rtl/pgs_gate_bank.sv
module pgs_gate_bank
    import pgs_pkg::*;
#(
    parameter logic [N_GATES-1:0] PRESENT    = 4'b1111,
    parameter logic [N_GATES-1:0] SHARED     = 4'b0000,
    parameter bit                 KEEP_RESET = 1'b0
) (
    input  logic               clk,
    input  logic               rst,
    input  step_s              act,
    input  logic               shared_go,
    output logic [N_GATES-1:0] open_vec
);

    generate
        for (genvar g = 0; g < N_GATES; g++) begin : g_gate
            if (PRESENT[g] && !(g == int'(G_RST) && KEEP_RESET)) begin : g_live
                logic q;
                logic hit;
                assign hit = act.valid && (act.gate == gate_e'(g))
                          && (act.shared_grp == SHARED[g])
                          && (!SHARED[g] || shared_go);
                always_ff @(posedge clk) begin
                    if (rst)      q <= 1'b0;
                    else if (hit) q <= act.turn_on;
                end
                assign open_vec[g] = q;
            end else begin : g_tied
                assign open_vec[g] = 1'b0;
            end
        end
    endgenerate

    // R6
    one_step_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(open_vec ^ $past(open_vec)) <= 1);

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !act.valid |=> $stable(open_vec));

endmodule

// File: rtl/periph_gate_seq.sv
module periph_gate_seq
    import pgs_pkg::*;
#(
    parameter int                 NUM_USERS      = 4,
    parameter logic [N_GATES-1:0] PRESENT        = 4'b1111,
    parameter logic [N_GATES-1:0] SHARED         = 4'b0011,
    parameter bit                 MOD_ACTIVE_LOW = 1'b0,
    parameter bit                 KEEP_RESET     = 1'b0,
    parameter bit                 READ_ONLY      = 1'b0
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         en_req,
    input  logic                         dis_req,
    input  logic [$clog2(NUM_USERS)-1:0] req_slot,
    output logic                         busy,
    output logic                         rst_release,
    output logic                         bus_gate,
    output logic                         mod_gate,
    output logic                         mem_gate,
    output logic                         enabled,
    output logic [NUM_USERS-1:0]         user_mask
);

    step_s              act;
    logic               shared_go;
    logic [N_GATES-1:0] open_vec;

    pgs_seq_ctrl #(
        .NUM_USERS (NUM_USERS),
        .READ_ONLY (READ_ONLY)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .en_req    (en_req),
        .dis_req   (dis_req),
        .req_slot  (req_slot),
        .busy      (busy),
        .act       (act),
        .shared_go (shared_go),
        .user_mask (user_mask)
    );

    pgs_gate_bank #(
        .PRESENT    (PRESENT),
        .SHARED     (SHARED),
        .KEEP_RESET (KEEP_RESET)
    ) u_bank (
        .clk       (clk),
        .rst       (rst),
        .act       (act),
        .shared_go (shared_go),
        .open_vec  (open_vec)
    );

    assign rst_release = open_vec[G_RST];
    assign bus_gate    = open_vec[G_BUS];
    assign mod_gate    = MOD_ACTIVE_LOW ? ~open_vec[G_MOD] : open_vec[G_MOD];
    assign mem_gate    = open_vec[G_MEM];
    assign enabled     = &(open_vec | ~PRESENT);

    // R10
    status_chk: assert property (@(posedge clk) disable iff (rst)
        enabled |-> ((rst_release || !PRESENT[G_RST]) && (bus_gate || !PRESENT[G_BUS])
                     && (mem_gate || !PRESENT[G_MEM])));

    generate
        if (KEEP_RESET) begin : g_keep_chk
            // R8
            keep_rst_chk: assert property (@(posedge clk) disable iff (rst)
                !rst_release);
        end
    endgenerate

endmodule

// File: tb/tb_periph_gate_seq.sv
module tb_periph_gate_seq;

    localparam int          NU  = 4;
    localparam logic [3:0]  SHR = 4'b0011;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // main instance
    logic       en_req = 1'b0, dis_req = 1'b0;
    logic [1:0] req_slot = '0;
    logic       busy, rst_rel, bus_g, mod_g, mem_g, enab;
    logic [3:0] mask;

    periph_gate_seq #(.NUM_USERS(NU), .PRESENT(4'b1111), .SHARED(SHR)) dut (
        .clk(clk), .rst(rst), .en_req(en_req), .dis_req(dis_req), .req_slot(req_slot),
        .busy(busy), .rst_release(rst_rel), .bus_gate(bus_g), .mod_gate(mod_g),
        .mem_gate(mem_g), .enabled(enab), .user_mask(mask));

    // option instances share one stimulus
    logic x_en = 1'b0, x_dis = 1'b0;
    logic b_busy, b_rst, b_bus, b_mod, b_mem, b_en;
    logic c_busy, c_rst, c_bus, c_mod, c_mem, c_en;
    logic d_busy, d_rst, d_bus, d_mod, d_mem, d_en;
    logic [3:0] b_mask, c_mask, d_mask;

    periph_gate_seq #(.NUM_USERS(NU), .PRESENT(4'b0111), .SHARED(4'b0000),
                      .MOD_ACTIVE_LOW(1'b1), .KEEP_RESET(1'b1)) dut_b (
        .clk(clk), .rst(rst), .en_req(x_en), .dis_req(x_dis), .req_slot(2'd0),
        .busy(b_busy), .rst_release(b_rst), .bus_gate(b_bus), .mod_gate(b_mod),
        .mem_gate(b_mem), .enabled(b_en), .user_mask(b_mask));

    periph_gate_seq #(.NUM_USERS(NU), .PRESENT(4'b1010), .SHARED(4'b1000)) dut_c (
        .clk(clk), .rst(rst), .en_req(x_en), .dis_req(x_dis), .req_slot(2'd0),
        .busy(c_busy), .rst_release(c_rst), .bus_gate(c_bus), .mod_gate(c_mod),
        .mem_gate(c_mem), .enabled(c_en), .user_mask(c_mask));

    periph_gate_seq #(.NUM_USERS(NU), .PRESENT(4'b1111), .SHARED(4'b0011),
                      .READ_ONLY(1'b1)) dut_d (
        .clk(clk), .rst(rst), .en_req(x_en), .dis_req(x_dis), .req_slot(2'd0),
        .busy(d_busy), .rst_release(d_rst), .bus_gate(d_bus), .mod_gate(d_mod),
        .mem_gate(d_mem), .enabled(d_en), .user_mask(d_mask));

    // scoreboard
    typedef struct {
        int         due;
        logic [3:0] gates;   // {mem, mod, bus, rst}
        logic       busy;
        logic       enab;
        logic [3:0] mask;
        string      tag;
    } item_t;

    item_t      sbq[$];
    logic [3:0] m_open = '0;
    logic [3:0] m_mask = '0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (sbq.size() > 0 && sbq[0].due <= cyc) begin
            item_t it;
            it = sbq.pop_front();
            if (it.due != cyc) check({it.tag, " timing"}, 32'(cyc), 32'(it.due));
            check({it.tag, " gates"}, 32'({mem_g, mod_g, bus_g, rst_rel}), 32'(it.gates));
            check({it.tag, " busy R6"}, 32'(busy), 32'(it.busy));
            check({it.tag, " enabled R10"}, 32'(enab), 32'(it.enab));
            check({it.tag, " mask"}, 32'(mask), 32'(it.mask));
        end
    end

    // Model: power-up walks shared then private, gates rst,bus,mod,mem;
    // power-down walks private then shared, gates mem,mod,bus,rst.
    task automatic push_model(input bit on, input int slot, input int acc, input string tag);
        logic go;
        logic [3:0] bitm;
        bitm = 4'(1 << slot);
        if (on) begin
            go = (m_mask == 4'b0);
            m_mask = m_mask | bitm;
        end else begin
            go = (m_mask != 4'b0) && ((m_mask & ~bitm) == 4'b0);
            m_mask = m_mask & ~bitm;
        end
        for (int s = 0; s < 8; s++) begin
            int  g;
            bit  grp_sh;
            item_t it;
            g      = on ? (s % 4) : (3 - (s % 4));
            grp_sh = on ? (s < 4) : (s >= 4);
            if (SHR[g] == grp_sh && (!grp_sh || go)) m_open[g] = on;
            it.due   = acc + 1 + s;
            it.gates = m_open;
            it.busy  = (s < 7);
            it.enab  = &m_open;
            it.mask  = m_mask;
            it.tag   = tag;
            sbq.push_back(it);
        end
    endtask

    task automatic request(input bit on, input int slot, input bit poke, input string tag);
        int acc;
        @(negedge clk);
        en_req   = on;
        dis_req  = !on;
        req_slot = 2'(slot);
        acc      = cyc + 1;
        push_model(on, slot, acc, tag);
        @(negedge clk);
        en_req  = 1'b0;
        dis_req = 1'b0;
        if (poke) begin
            // R6: a request while busy must be ignored
            repeat (2) @(negedge clk);
            dis_req  = on;
            en_req   = !on;
            req_slot = 2'd3;
            @(negedge clk);
            en_req  = 1'b0;
            dis_req = 1'b0;
        end
        while (cyc < acc + 9) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 gates", 32'({mem_g, mod_g, bus_g, rst_rel}), 32'h0);
        check("R1 mask", 32'(mask), 32'h0);
        check("R1 busy", 32'(busy), 32'h0);
        check("R1 enabled", 32'(enab), 32'h0);
        // R7 active-low module gate closed level after reset
        check("R7 reset level", 32'(b_mod), 32'h1);

        request(1'b1, 0, 1'b0, "R2 R4 first enable");
        request(1'b1, 2, 1'b0, "R4 second enable shared skipped");
        request(1'b0, 0, 1'b0, "R3 R5 disable with peer left");
        request(1'b0, 2, 1'b0, "R3 R5 last disable");
        request(1'b0, 1, 1'b0, "R5 empty-mask disable");
        request(1'b1, 3, 1'b1, "R6 enable with poke");
        check("R6 poke ignored mask", 32'(mask), 32'h8);
        request(1'b0, 3, 1'b1, "R6 disable with poke");
        check("R6 poke ignored gates", 32'({mem_g, mod_g, bus_g, rst_rel}), 32'h0);

        // option builds
        @(negedge clk);
        x_en = 1'b1;
        @(negedge clk);
        x_en = 1'b0;
        @(negedge clk);
        check("R9 read-only busy", 32'(d_busy), 32'h0);
        repeat (10) @(negedge clk);
        check("R8 reset kept", 32'(b_rst), 32'h0);
        check("R7 open level", 32'(b_mod), 32'h0);
        check("R7 bus open", 32'(b_bus), 32'h1);
        check("R10 absent mem closed level", 32'(b_mem), 32'h0);
        check("R10 reset held lowers status", 32'(b_en), 32'h0);
        check("R10 absent bits count open", 32'(c_en), 32'h1);
        check("R10 absent outputs", 32'({c_mod, c_rst}), 32'h0);
        check("R10 present gates", 32'({c_mem, c_bus}), 32'h3);
        check("R9 read-only outputs", 32'({d_mem, d_mod, d_bus, d_rst, d_en}), 32'h0);
        check("R9 read-only mask", 32'(d_mask), 32'h0);
        x_dis = 1'b1;
        @(negedge clk);
        x_dis = 1'b0;
        repeat (10) @(negedge clk);
        check("R7 closed level after disable", 32'(b_mod), 32'h1);
        check("R8 reset kept after disable", 32'(b_rst), 32'h0);
        check("R9 read-only after disable", 32'(d_busy), 32'h0);
        check("R5 shared closed on empty mask", 32'({c_mem, c_bus, c_mask}), 32'h0);

        check("scoreboard drained", 32'(sbq.size()), 32'h0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule